// File: doc/BRIEF.md
# Multichannel Conversion Result Readout Controller

This block sits between four simultaneously sampled converter channels and a host. Holding the run input high starts continuous conversion, but only after the input has stayed high for a qualification window. A short glitch therefore cannot trigger a conversion. Each accepted sample set is copied into a shadow register in one clock cycle. The active-low end-of-conversion output then goes low and stays low until the host has consumed every active channel of that set.

The host can fetch results in several ways through a select/strobe read port: one channel at a time, two channels together as a pair, or all four at once. Every read returns data from the shadow register, so a pair or quad read always holds values from one conversion instant. If a new set arrives before the previous one has been fully read, the new set overwrites the old one and a sticky overrun flag is raised. The host reads and clears that flag through a status selection.

Setting any per-channel scan enable bit selects scan mode. On a falling edge of chip select, the block latches a frame and streams the enabled channels, one word per cycle. Only the enabled channels count toward end-of-conversion.

Top module: `cnv_readout_ctrl`

## Requirements
- R1: `conv_go_o` rises only after `run_i` has been sampled high on RUN_QUAL (default 4) consecutive clock edges, so that after n edges with run high it is 1 exactly when n >= RUN_QUAL. It returns to 0 right after the first edge that samples `run_i` low. A shorter pulse never raises it.
- R2: A strobe on `smp_valid_i` while `conv_go_o` is 0 is ignored. The end-of-conversion output stays high and the stored results stay unchanged.
- R3: `eoc_n_o` is 1 during and after reset. It is 0 after the clock edge that accepts a sample set (`smp_valid_i` and `conv_go_o` both high).
- R4: `eoc_n_o` returns to 1 only after every active channel of the current set has been read. All four channels are active when `scan_en_i` is 0; otherwise only the channels whose enable bit is set are active.
- R5: Selections 0 to 3 read channel A to D. The value is returned unchanged in 16-bit two's complement in `rd_data_o[15:0]` (0x7FFF, 0x0000, 0xFFFF and 0x8000 pass as they are), the upper bits are 0, and `rd_valid_o` is high for the cycle after the strobe.
- R6: Selection 4 returns A in [31:16] and B in [15:0]. Selection 5 returns C in [31:16] and D in [15:0]. Selection 6 returns A in [63:48], B in [47:32], C in [31:16] and D in [15:0]. All values in one read come from the same sample set.
- R7: Reads return the shadow copy captured at acceptance. Changes on `smp_data_i` without an accepted strobe do not affect read data.
- R8: Accepting a set while any active channel of the previous set is unread sets `ovr_o`, and the new set replaces the old one. Selection 7 returns the overrun flag in bit 0 and "results pending" in bit 1, and clears `ovr_o`.
- R9: With `scan_en_i` nonzero, a falling edge of `cs_n_i` (one sample high, the next low) starts a stream. The enabled channels come out on `scan_data_o` in ascending order (A first), one per cycle with `scan_valid_o` high, starting at the second edge that samples `cs_n_i` low. When `scan_en_i` is 0, no stream starts.
- R10: All words of a stream come from the set latched at the chip-select falling edge. An emitted word marks its channel read only if no newer set has arrived since. Raising `cs_n_i` stops the stream, and unsent channels stay pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Continuous conversion request |
| conv_go_o | output | 1 | Qualified conversion enable to the converters |
| smp_valid_i | input | 1 | Strobe: a new four-channel sample set is on `smp_data_i` |
| smp_data_i | input | 64 | Channel results, channel k at [16k+15:16k] |
| scan_en_i | input | 4 | Per-channel scan enable, bit 0 = channel A |
| eoc_n_o | output | 1 | Active-low end of conversion |
| ovr_o | output | 1 | Sticky overrun flag |
| rd_en_i | input | 1 | Host read strobe |
| rd_sel_i | input | 3 | Read selection code |
| rd_data_o | output | 64 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| cs_n_i | input | 1 | Active-low chip select for scan streaming |
| scan_data_o | output | 16 | Streamed channel word |
| scan_valid_o | output | 1 | Streamed word valid |

## Verification
The read port is driven with all eight selection codes on distinct sample sets, so that swapped halves, wrong channel indices and wrong clear masks each show up as a data or end-of-conversion mismatch. A value set at the signed extremes shows whether any sign or bit manipulation creeps into the path. Scan streaming is swept over all fifteen non-zero enable masks, which tells apart ordering, skipping and pending-clear errors per channel pattern. A run-pulse sweep from 1 to 6 cycles separates an exact qualification count from an off-by-one. Injecting a set in the middle of a stream and aborting a stream separate a coherent latched frame and stale-aware clearing from a design that reads live shadow data.

// File: rtl/cnv_pkg.sv
`timescale 1ns/1ps
package cnv_pkg;
  localparam int NCH = 4;

  typedef enum logic [2:0] {
    SEL_CH_A    = 3'd0,
    SEL_CH_B    = 3'd1,
    SEL_CH_C    = 3'd2,
    SEL_CH_D    = 3'd3,
    SEL_PAIR_AB = 3'd4,
    SEL_PAIR_CD = 3'd5,
    SEL_QUAD    = 3'd6,
    SEL_STATUS  = 3'd7
  } rd_sel_e;
endpackage

// File: rtl/cnv_run_qual.sv
`timescale 1ns/1ps
module cnv_run_qual #(
  parameter int RUN_QUAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic go_o
);
  localparam int CW = $clog2(RUN_QUAL + 1);
  localparam logic [CW-1:0] QMAX = CW'(RUN_QUAL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          go_q, go_d;

  // saturating count of consecutive high samples
  always_comb begin
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == QMAX) cnt_d = cnt_q;
    else                    cnt_d = cnt_q + 1'b1;
    go_d = (cnt_d == QMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      go_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      go_q  <= go_d;
    end
  end

  assign go_o = go_q;
endmodule

// File: rtl/cnv_snapshot.sv
`timescale 1ns/1ps
module cnv_snapshot import cnv_pkg::*; #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             new_set_i,
  input  logic [NCH*W-1:0] smp_data_i,
  input  logic [NCH-1:0]   active_i,
  input  logic [NCH-1:0]   clr_i,
  input  logic             ovr_clr_i,
  output logic [NCH*W-1:0] shadow_o,
  output logic [NCH-1:0]   pend_o,
  output logic             ovr_o
);
  logic [NCH*W-1:0] shadow_q, shadow_d;
  logic [NCH-1:0]   pend_q, pend_d, pend_left;
  logic             ovr_q, ovr_d;

  always_comb begin
    pend_left = pend_q & ~clr_i;
    shadow_d  = new_set_i ? smp_data_i : shadow_q;
    pend_d    = new_set_i ? active_i : pend_left;
    if (new_set_i && (|pend_left)) ovr_d = 1'b1;
    else if (ovr_clr_i)            ovr_d = 1'b0;
    else                           ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (new_set_i) shadow_q <= shadow_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  assign shadow_o = shadow_q;
  assign pend_o   = pend_q;
  assign ovr_o    = ovr_q;
endmodule

// File: rtl/cnv_host_rd.sv
`timescale 1ns/1ps
module cnv_host_rd import cnv_pkg::*; #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_sel_i,
  input  logic [NCH*W-1:0] shadow_i,
  input  logic             ovr_i,
  input  logic             pend_any_i,
  output logic [NCH*W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic [NCH-1:0]   clr_o,
  output logic             ovr_clr_o
);
  logic [W-1:0]     ch [NCH];
  logic [NCH*W-1:0] data_d, rd_data_q, rd_data_n;
  logic [NCH-1:0]   mask_d;
  logic             stat_d;
  logic             rd_valid_q;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch[k] = shadow_i[k*W +: W];
  end

  always_comb begin
    data_d = '0;
    mask_d = '0;
    stat_d = 1'b0;
    unique case (rd_sel_e'(rd_sel_i))
      SEL_CH_A, SEL_CH_B, SEL_CH_C, SEL_CH_D: begin
        data_d[W-1:0]          = ch[rd_sel_i[1:0]];
        mask_d[rd_sel_i[1:0]]  = 1'b1;
      end
      SEL_PAIR_AB: begin
        data_d[2*W-1:W] = ch[0];
        data_d[W-1:0]   = ch[1];
        mask_d          = 4'b0011;
      end
      SEL_PAIR_CD: begin
        data_d[2*W-1:W] = ch[2];
        data_d[W-1:0]   = ch[3];
        mask_d          = 4'b1100;
      end
      SEL_QUAD: begin
        for (int k = 0; k < NCH; k++) data_d[(NCH-1-k)*W +: W] = ch[k];
        mask_d = '1;
      end
      SEL_STATUS: begin
        data_d[1:0] = {pend_any_i, ovr_i};
        stat_d      = 1'b1;
      end
      default: ;
    endcase
    rd_data_n = rd_en_i ? data_d : rd_data_q;
  end

  assign clr_o     = rd_en_i ? mask_d : '0;
  assign ovr_clr_o = rd_en_i & stat_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_q <= rd_data_n;
      rd_valid_q <= rd_en_i;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/cnv_scan.sv
`timescale 1ns/1ps
module cnv_scan import cnv_pkg::*; #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_i,
  input  logic [NCH-1:0]   scan_en_i,
  input  logic [NCH*W-1:0] shadow_i,
  input  logic             new_set_i,
  output logic [W-1:0]     word_o,
  output logic             valid_o,
  output logic [NCH-1:0]   clr_o
);
  localparam int IW = $clog2(NCH);

  logic             cs_q;
  logic [NCH-1:0]   remain_q, remain_d;
  logic [NCH*W-1:0] frame_q;
  logic             stale_q, stale_d;
  logic [W-1:0]     word_q, word_d;
  logic             valid_q;
  logic             fall, load, emit, found;
  logic [IW-1:0]    idx;
  logic [NCH-1:0]   pick;

  assign fall = cs_q & ~cs_n_i;
  assign load = fall & (|scan_en_i);
  assign emit = ~cs_n_i & (|remain_q);

  // lowest pending channel goes first
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int k = 0; k < NCH; k++) begin
      if (remain_q[k] && !found) begin
        idx   = IW'(k);
        found = 1'b1;
      end
    end
    pick      = '0;
    pick[idx] = found;
  end

  always_comb begin
    remain_d = remain_q;
    stale_d  = stale_q | new_set_i;
    word_d   = word_q;
    if (cs_n_i) begin
      remain_d = '0;
    end else if (load) begin
      remain_d = scan_en_i;
      stale_d  = new_set_i;
    end else if (emit) begin
      remain_d = remain_q & ~pick;
      word_d   = frame_q[idx*W +: W];
    end
  end

  assign clr_o = (emit && !stale_q && !new_set_i) ? pick : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      remain_q <= '0;
      frame_q  <= '0;
      stale_q  <= 1'b0;
      word_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      cs_q     <= cs_n_i;
      remain_q <= remain_d;
      stale_q  <= stale_d;
      if (load) frame_q <= shadow_i;
      if (emit) word_q  <= word_d;
      valid_q  <= emit;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cnv_readout_ctrl.sv
`timescale 1ns/1ps
module cnv_readout_ctrl import cnv_pkg::*; #(
  parameter int W        = 16,
  parameter int RUN_QUAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic             conv_go_o,
  input  logic             smp_valid_i,
  input  logic [NCH*W-1:0] smp_data_i,
  input  logic [NCH-1:0]   scan_en_i,
  output logic             eoc_n_o,
  output logic             ovr_o,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_sel_i,
  output logic [NCH*W-1:0] rd_data_o,
  output logic             rd_valid_o,
  input  logic             cs_n_i,
  output logic [W-1:0]     scan_data_o,
  output logic             scan_valid_o
);
  logic             rst_meta, rst_n_s;
  logic             go, new_set;
  logic [NCH-1:0]   active, pend, rd_clr, scan_clr;
  logic [NCH*W-1:0] shadow;
  logic             ovr_clr;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  assign new_set = smp_valid_i & go;
  assign active  = (|scan_en_i) ? scan_en_i : '1;

  cnv_run_qual #(.RUN_QUAL(RUN_QUAL)) u_qual (
    .clk   (clk),
    .rst_n (rst_n_s),
    .run_i (run_i),
    .go_o  (go)
  );

  cnv_snapshot #(.W(W)) u_snap (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .new_set_i  (new_set),
    .smp_data_i (smp_data_i),
    .active_i   (active),
    .clr_i      (rd_clr | scan_clr),
    .ovr_clr_i  (ovr_clr),
    .shadow_o   (shadow),
    .pend_o     (pend),
    .ovr_o      (ovr_o)
  );

  cnv_host_rd #(.W(W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .rd_en_i    (rd_en_i),
    .rd_sel_i   (rd_sel_i),
    .shadow_i   (shadow),
    .ovr_i      (ovr_o),
    .pend_any_i (|pend),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .clr_o      (rd_clr),
    .ovr_clr_o  (ovr_clr)
  );

  cnv_scan #(.W(W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_n_i    (cs_n_i),
    .scan_en_i (scan_en_i),
    .shadow_i  (shadow),
    .new_set_i (new_set),
    .word_o    (scan_data_o),
    .valid_o   (scan_valid_o),
    .clr_o     (scan_clr)
  );

  assign conv_go_o = go;
  assign eoc_n_o   = ~(|pend);
endmodule

// File: rtl/cnv_readout_chk.sv
`timescale 1ns/1ps
module cnv_readout_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run_i,
  input logic       conv_go_o,
  input logic       smp_valid_i,
  input logic       eoc_n_o,
  input logic       ovr_o,
  input logic       rd_en_i,
  input logic [2:0] rd_sel_i,
  input logic       rd_valid_o,
  input logic       cs_n_i,
  input logic       scan_valid_o
);
  AST_GO_FOLLOWS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o |-> $past(run_i)); // R1
  AST_EOC_FALL_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n_o) |-> $past(smp_valid_i && conv_go_o)); // R2
  AST_EOC_ON_NEW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && conv_go_o) |=> !eoc_n_o); // R3
  AST_EOC_RISE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_n_o) |-> ($past(rd_en_i) || scan_valid_o)); // R4
  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R5
  AST_RD_VALID_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(rd_en_i)); // R5
  AST_OVR_CLEAR_BY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_o) |-> $past(rd_en_i && rd_sel_i == 3'd7)); // R8
  AST_SCAN_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid_o |-> $past(!cs_n_i)); // R9
endmodule

bind cnv_readout_ctrl cnv_readout_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n_s),
  .run_i        (run_i),
  .conv_go_o    (conv_go_o),
  .smp_valid_i  (smp_valid_i),
  .eoc_n_o      (eoc_n_o),
  .ovr_o        (ovr_o),
  .rd_en_i      (rd_en_i),
  .rd_sel_i     (rd_sel_i),
  .rd_valid_o   (rd_valid_o),
  .cs_n_i       (cs_n_i),
  .scan_valid_o (scan_valid_o)
);

// File: tb/tb_cnv_readout_ctrl.sv
`timescale 1ns/1ps
module tb_cnv_readout_ctrl;
  import cnv_pkg::*;
  localparam int W  = 16;
  localparam int RQ = 4;
  localparam int DW = NCH * W;

  logic          clk = 1'b0;
  logic          rst_n, run, conv_go, smp_valid, eoc_n, ovr;
  logic [DW-1:0] smp_data, rd_data;
  logic [NCH-1:0] scan_en;
  logic          rd_en, rd_valid, cs_n, scan_valid;
  logic [2:0]    rd_sel;
  logic [W-1:0]  scan_data;

  always #2.5 clk = ~clk;

  cnv_readout_ctrl #(.W(W), .RUN_QUAL(RQ)) dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .conv_go_o(conv_go),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .scan_en_i(scan_en),
    .eoc_n_o(eoc_n), .ovr_o(ovr), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .cs_n_i(cs_n),
    .scan_data_o(scan_data), .scan_valid_o(scan_valid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] got [8];
  int ng;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [DW-1:0] mkset(int s);
    logic [DW-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*W +: W] = 16'((s * 40503 + c * 9973 + 17) & 16'hFFFF);
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_rd(logic [DW-1:0] d, int sel);
    logic [DW-1:0] r;
    r = '0;
    if (sel < 4) r[W-1:0] = d[sel*W +: W];
    else if (sel == 4) r[2*W-1:0] = {d[W-1:0], d[2*W-1:W]};
    else if (sel == 5) r[2*W-1:0] = {d[3*W-1:2*W], d[4*W-1:3*W]};
    else if (sel == 6) r = {d[W-1:0], d[2*W-1:W], d[3*W-1:2*W], d[4*W-1:3*W]};
    return r;
  endfunction

  task automatic push(input logic [DW-1:0] d);
    smp_data = d;
    smp_valid = 1'b1;
    tick();
    smp_valid = 1'b0;
    smp_data = ~d;
  endtask

  task automatic rd(input int sel, output logic [DW-1:0] q);
    rd_sel = 3'(sel);
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, "R5 rd_valid after strobe", DW'(rd_valid), 1);
    q = rd_data;
  endtask

  task automatic scan_run(input int ncyc);
    ng = 0;
    cs_n = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      tick();
      if (scan_valid && ng < 8) begin
        got[ng] = scan_data;
        ng++;
      end
    end
    cs_n = 1'b1;
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q, d, d2;
    int j;
    rst_n = 1'b0; run = 1'b0; smp_valid = 1'b0; smp_data = '0; scan_en = '0;
    rd_en = 1'b0; rd_sel = '0; cs_n = 1'b1;
    repeat (3) tick();
    chk(eoc_n == 1'b1, "R3 eoc high in reset", DW'(eoc_n), 1);
    chk(conv_go == 1'b0, "R1 go low in reset", DW'(conv_go), 0);
    chk(ovr == 1'b0, "R8 ovr low in reset", DW'(ovr), 0);
    chk(scan_valid == 1'b0, "R9 no scan in reset", DW'(scan_valid), 0);
    chk(rd_valid == 1'b0, "R5 no rd_valid in reset", DW'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: run pulse length sweep
    for (int len = 1; len <= 6; len++) begin
      run = 1'b1;
      for (int i = 1; i <= len; i++) begin
        tick();
        chk(conv_go == (i >= RQ), "R1 go vs run length", DW'(conv_go), DW'(i >= RQ));
      end
      run = 1'b0;
      tick();
      chk(conv_go == 1'b0, "R1 go drops with run", DW'(conv_go), 0);
      tick();
    end

    // R2: sample strobe while not running is ignored
    push(mkset(1));
    chk(eoc_n == 1'b1, "R2 eoc stays high when idle", DW'(eoc_n), 1);
    rd(6, q);
    chk(q == '0, "R2 shadow unchanged when idle", q, '0);

    run = 1'b1;
    repeat (RQ) tick();
    chk(conv_go == 1'b1, "R1 go after qualification", DW'(conv_go), 1);

    // R5/R6: every selection on distinct sets
    for (int s = 0; s < 7; s++) begin
      d = mkset(10 + s);
      push(d);
      chk(eoc_n == 1'b0, "R3 eoc low after set", DW'(eoc_n), 0);
      rd(s, q);
      chk(q == exp_rd(d, s), (s < 4) ? "R5 single read data" : "R6 grouped read data", q, exp_rd(d, s));
      chk(eoc_n == (s == 6), "R4 eoc after partial read", DW'(eoc_n), DW'(s == 6));
      rd(6, q);
      chk(eoc_n == 1'b1, "R4 eoc high after all read", DW'(eoc_n), 1);
    end

    // R4: eoc only after the last channel
    d = mkset(30);
    push(d);
    for (int s = 0; s < 4; s++) begin
      rd(s, q);
      chk(eoc_n == (s == 3), "R4 eoc per single read", DW'(eoc_n), DW'(s == 3));
    end
    push(mkset(31));
    rd(4, q);
    chk(eoc_n == 1'b0, "R4 eoc low after AB", DW'(eoc_n), 0);
    rd(5, q);
    chk(eoc_n == 1'b1, "R4 eoc high after CD", DW'(eoc_n), 1);

    // R7: live input changes do not leak into reads
    d = mkset(32);
    push(d);
    for (int i = 0; i < 4; i++) begin
      smp_data = mkset(100 + i);
      tick();
    end
    rd(6, q);
    chk(q == exp_rd(d, 6), "R7 read from shadow", q, exp_rd(d, 6));

    // R5: two's complement extremes pass unchanged
    d = {16'h8000, 16'hFFFF, 16'h0000, 16'h7FFF};
    push(d);
    for (int s = 0; s < 4; s++) begin
      rd(s, q);
      chk(q == exp_rd(d, s), "R5 signed extreme value", q, exp_rd(d, s));
    end

    // R8: overrun
    push(mkset(20));
    chk(ovr == 1'b0, "R8 no ovr on clean set", DW'(ovr), 0);
    d2 = mkset(21);
    push(d2);
    chk(ovr == 1'b1, "R8 ovr on unread set", DW'(ovr), 1);
    rd(7, q);
    chk(q[1:0] == 2'b11, "R8 status bits", DW'(q[1:0]), 3);
    chk(ovr == 1'b0, "R8 ovr cleared by status", DW'(ovr), 0);
    rd(6, q);
    chk(q == exp_rd(d2, 6), "R8 newer set overwrote", q, exp_rd(d2, 6));
    rd(7, q);
    chk(q[1:0] == 2'b00, "R8 status after clear", DW'(q[1:0]), 0);

    // R4: disabled channels do not hold eoc
    scan_en = 4'b0101;
    push(mkset(22));
    rd(0, q);
    chk(eoc_n == 1'b0, "R4 eoc low with C unread", DW'(eoc_n), 0);
    rd(2, q);
    chk(eoc_n == 1'b1, "R4 disabled B,D ignored", DW'(eoc_n), 1);

    // R9/R10: scan sweep over all masks
    for (int m = 1; m < 16; m++) begin
      scan_en = 4'(m);
      d = mkset(40 + m);
      push(d);
      scan_run(8);
      chk(ng == $countones(4'(m)), "R9 scan word count", DW'(ng), DW'($countones(4'(m))));
      j = 0;
      for (int c = 0; c < NCH; c++) begin
        if (m[c] && j < ng) begin
          chk(got[j] == d[c*W +: W], "R9 scan order and data", DW'(got[j]), DW'(d[c*W +: W]));
          j++;
        end
      end
      chk(eoc_n == 1'b1, "R10 scan clears pending", DW'(eoc_n), 1);
    end

    // R9: no stream without scan mode
    scan_en = '0;
    push(mkset(50));
    scan_run(6);
    chk(ng == 0, "R9 no scan when disabled", DW'(ng), 0);
    chk(eoc_n == 1'b0, "R9 eoc untouched by cs", DW'(eoc_n), 0);
    rd(6, q);

    // R10: new set mid-stream, frame stays coherent
    scan_en = 4'hF;
    d = mkset(60);
    d2 = mkset(61);
    push(d);
    ng = 0;
    cs_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 2) begin
        smp_data = d2;
        smp_valid = 1'b1;
      end
      tick();
      smp_valid = 1'b0;
      if (scan_valid && ng < 8) begin
        got[ng] = scan_data;
        ng++;
      end
    end
    cs_n = 1'b1;
    tick();
    chk(ng == 4, "R10 full frame sent", DW'(ng), 4);
    for (int c = 0; c < 4; c++)
      chk(got[c] == d[c*W +: W], "R10 coherent frame", DW'(got[c]), DW'(d[c*W +: W]));
    chk(eoc_n == 1'b0, "R10 new set still pending", DW'(eoc_n), 0);
    chk(ovr == 1'b1, "R8 ovr during stream", DW'(ovr), 1);
    rd(7, q);
    rd(6, q);
    chk(q == exp_rd(d2, 6), "R10 newer set in shadow", q, exp_rd(d2, 6));

    // R10: abort mid-stream
    push(mkset(70));
    cs_n = 1'b0;
    tick();
    tick();
    chk(scan_valid == 1'b1, "R9 first word timing", DW'(scan_valid), 1);
    cs_n = 1'b1;
    tick();
    chk(scan_valid == 1'b0, "R10 stream stops", DW'(scan_valid), 0);
    tick();
    chk(scan_valid == 1'b0, "R10 stream stays stopped", DW'(scan_valid), 0);
    chk(eoc_n == 1'b0, "R10 unsent channels pending", DW'(eoc_n), 0);
    rd(6, q);
    chk(eoc_n == 1'b1, "R4 eoc after quad read", DW'(eoc_n), 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule